// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a character clock into everything a character-based CRT display needs for timing: horizontal and vertical sync pulses, a display-enable window, a 14-bit video memory address and the scan line number inside the current character row. Each clock is one character slot. A small set of timing registers, written through an index latch and a data strobe, sets the line length, the frame height, the display area and where the sync pulses fall.

All registers may be rewritten while the picture is running. Counter comparisons are tolerant of a limit that drops below the running count, and the start address is taken in only when the whole frame wraps. Software can therefore shrink the vertical total and the row height and reprogram the start address on the fly. This stacks several short frames, each with its own memory window, inside one monitor frame. The sync width can go down to two characters, so very short lines still carry a well-formed horizontal pulse.

Every output is registered and shows the counter state of the previous character slot.

Top module: `rtg_top`

## Requirements
- R1: While `rst` is high, `hsync_o`, `vsync_o`, `de_o`, `ma_o` and `ra_o` are all zero, and every timing register returns to its default value.
- R2: A scan line lasts (line-total register, index 0) + 1 characters. The default of 63 gives 64-character lines, so successive `hsync_o` rising edges are exactly that many clocks apart.
- R3: A frame lasts ((row-total register, index 4) + 1) × ((row-height register, index 9) + 1) + (adjust register, index 5) scan lines. The defaults 38, 7 and 0 give 312 lines of 64 characters.
- R4: `hsync_o` rises at the character whose horizontal position equals index 2 and stays high for the number of characters in index 3 (4 bits). A width of 2 yields a 2-character pulse, and a width of 0 yields no pulse.
- R5: `vsync_o` rises on character 0 of scan line 0 of the row numbered by index 7 and stays high for exactly 16 scan lines.
- R6: `de_o` is high only when the horizontal position is below index 1, the row number is below index 6 and the frame is not in its adjust lines.
- R7: While `de_o` is high, `ma_o` equals the current row base plus the horizontal position, modulo 2^14. The row base grows by the value of index 1 at each new character row.
- R8: `ra_o` gives the scan line inside the current row (0 up to index 9). Index 9 = 0 makes every row one scan line. Adjust lines count 0, 1, … up to index 5 − 1.
- R9: The start address (index 12 holds bits 13:8 in its low 6 bits, index 13 holds bits 7:0) becomes the row base only when the frame wraps. A write in the middle of a frame leaves the rest of that frame unchanged.
- R10: A pulse on `idx_we` latches `wdata[4:0]` as the selected index, and a pulse on `dat_we` writes `wdata` to the selected register. Only indices 0–7, 9, 12 and 13 exist. Writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Latch `wdata[4:0]` as register index |
| dat_we | input | 1 | Write `wdata` to the selected register |
| wdata | input | 8 | Index or register data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| ma_o | output | 14 | Video memory address |
| ra_o | output | 5 | Scan line within the character row |

## Verification
The scoreboard predicts every output on every clock of whole frames. It does this for the default 312-line frame and for a re-timed frame of one-line rows with two adjust lines, a 2-character sync and a start address near the top of the 14-bit space. A design that loaded the start address on any row boundary instead of only at the frame wrap would show the new window in the lower half of the frame in which the address was rewritten. One that did not wrap at 14 bits would put out wrong addresses in the re-timed frame. Adjust-line handling is targeted because an off-by-one there shifts the frame length and `ra_o`. A sync width of zero is targeted because a naive down-counter would turn it into a 16-character pulse. Writes to non-existent indices are followed by a complete frame comparison, which catches a decoder that aliases them onto real registers.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned DW   = 8;   // write data width
  localparam int unsigned IDXW = 5;   // register index width
  localparam int unsigned HCW  = 8;   // horizontal counter width
  localparam int unsigned VCW  = 7;   // row counter width
  localparam int unsigned RCW  = 5;   // scan line counter width
  localparam int unsigned HWW  = 4;   // hsync width field
  localparam int unsigned MAW  = 14;  // memory address width

  typedef struct packed {
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hdisp;
    logic [HCW-1:0] hpos;
    logic [HWW-1:0] hwid;
    logic [VCW-1:0] vtot;
    logic [RCW-1:0] vadj;
    logic [VCW-1:0] vdisp;
    logic [VCW-1:0] vsrow;
    logic [RCW-1:0] rmax;
    logic [MAW-1:0] start;
  } cfg_t;

  localparam logic [IDXW-1:0] IX_HTOT  = 5'd0;
  localparam logic [IDXW-1:0] IX_HDISP = 5'd1;
  localparam logic [IDXW-1:0] IX_HPOS  = 5'd2;
  localparam logic [IDXW-1:0] IX_HWID  = 5'd3;
  localparam logic [IDXW-1:0] IX_VTOT  = 5'd4;
  localparam logic [IDXW-1:0] IX_VADJ  = 5'd5;
  localparam logic [IDXW-1:0] IX_VDISP = 5'd6;
  localparam logic [IDXW-1:0] IX_VSROW = 5'd7;
  localparam logic [IDXW-1:0] IX_RMAX  = 5'd9;
  localparam logic [IDXW-1:0] IX_STHI  = 5'd12;
  localparam logic [IDXW-1:0] IX_STLO  = 5'd13;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idx_we,
  input  logic            dat_we,
  input  logic [DW-1:0]   wdata,
  output logic [IDXW-1:0] sel_o,
  output cfg_t            cfg_o
);
  localparam int unsigned HI_W = MAW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= '0;
      cfg_o <= RST_CFG;
    end else begin
      if (idx_we) sel_o <= wdata[IDXW-1:0];
      if (dat_we) begin
        case (sel_o)
          IX_HTOT:  cfg_o.htot  <= wdata[HCW-1:0];
          IX_HDISP: cfg_o.hdisp <= wdata[HCW-1:0];
          IX_HPOS:  cfg_o.hpos  <= wdata[HCW-1:0];
          IX_HWID:  cfg_o.hwid  <= wdata[HWW-1:0];
          IX_VTOT:  cfg_o.vtot  <= wdata[VCW-1:0];
          IX_VADJ:  cfg_o.vadj  <= wdata[RCW-1:0];
          IX_VDISP: cfg_o.vdisp <= wdata[VCW-1:0];
          IX_VSROW: cfg_o.vsrow <= wdata[VCW-1:0];
          IX_RMAX:  cfg_o.rmax  <= wdata[RCW-1:0];
          IX_STHI:  cfg_o.start[MAW-1:DW] <= wdata[HI_W-1:0];
          IX_STLO:  cfg_o.start[DW-1:0]   <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtg_hgen.sv
module rtg_hgen
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] htot,
  input  logic [HCW-1:0] hpos,
  input  logic [HWW-1:0] hwid,
  output logic [HCW-1:0] hcnt,
  output logic           h_end,
  output logic           line_start,
  output logic           hs_now
);
  logic [HWW-1:0] hs_left;
  logic           hs_hit;

  // ">=" so that a total lowered below the running count still wraps
  assign h_end      = (hcnt >= htot);
  assign line_start = (hcnt == '0);
  assign hs_hit     = (hcnt == hpos) && (hwid != '0);
  assign hs_now     = hs_hit || (hs_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      hs_left <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (hs_hit)               hs_left <= hwid - 1'b1;
      else if (hs_left != '0)   hs_left <= hs_left - 1'b1;
    end
  end
endmodule

// File: rtl/rtg_vgen.sv
module rtg_vgen
  import rtg_pkg::*;
#(
  parameter int unsigned VS_LINES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           h_end,
  input  logic           line_start,
  input  logic [VCW-1:0] vtot,
  input  logic [RCW-1:0] vadj,
  input  logic [VCW-1:0] vdisp,
  input  logic [VCW-1:0] vsrow,
  input  logic [RCW-1:0] rmax,
  output logic [RCW-1:0] rcnt,
  output logic [VCW-1:0] vcnt,
  output logic           in_adj,
  output logic           row_last_line,
  output logic           frame_wrap,
  output logic           v_disp,
  output logic           vs_now
);
  localparam int unsigned VSW = $clog2(VS_LINES + 1);

  logic           r_end, row_last, adj_end, enter_adj, vs_hit;
  logic [VSW-1:0] vs_lines;

  assign r_end         = (rcnt >= rmax);
  assign row_last      = (vcnt >= vtot);
  assign adj_end       = ({1'b0, rcnt} + 1'b1) >= {1'b0, vadj};
  assign row_last_line = !in_adj && r_end;
  assign frame_wrap    = h_end && (in_adj ? adj_end
                                          : (r_end && row_last && vadj == '0));
  assign enter_adj     = h_end && !in_adj && r_end && row_last && vadj != '0;
  assign v_disp        = !in_adj && (vcnt < vdisp);
  assign vs_hit        = line_start && rcnt == '0 && vcnt == vsrow && !in_adj;
  assign vs_now        = vs_hit || (vs_lines != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt     <= '0;
      vcnt     <= '0;
      in_adj   <= 1'b0;
      vs_lines <= '0;
    end else begin
      if (frame_wrap) begin
        rcnt   <= '0;
        vcnt   <= '0;
        in_adj <= 1'b0;
      end else if (enter_adj) begin
        rcnt   <= '0;
        in_adj <= 1'b1;
      end else if (h_end) begin
        if (!in_adj && r_end) begin
          rcnt <= '0;
          vcnt <= vcnt + 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
      if (vs_hit)                         vs_lines <= VSW'(VS_LINES);
      else if (h_end && vs_lines != '0)   vs_lines <= vs_lines - 1'b1;
    end
  end
endmodule

// File: rtl/rtg_addr.sv
module rtg_addr
  import rtg_pkg::*;
#(
  parameter logic [MAW-1:0] START_RST = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           h_end,
  input  logic           row_last_line,
  input  logic           frame_wrap,
  input  logic [HCW-1:0] hdisp,
  input  logic [MAW-1:0] start,
  output logic [MAW-1:0] ma_cnt
);
  logic [MAW-1:0] row_base, next_base;

  assign next_base = row_base + MAW'(hdisp);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base <= START_RST;
      ma_cnt   <= START_RST;
    end else if (frame_wrap) begin
      row_base <= start;
      ma_cnt   <= start;
    end else if (h_end) begin
      if (row_last_line) begin
        row_base <= next_base;
        ma_cnt   <= next_base;
      end else begin
        ma_cnt   <= row_base;
      end
    end else begin
      ma_cnt <= ma_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int unsigned P_HTOT   = 63,
  parameter int unsigned P_HDISP  = 40,
  parameter int unsigned P_HPOS   = 46,
  parameter int unsigned P_HWID   = 14,
  parameter int unsigned P_VTOT   = 38,
  parameter int unsigned P_VADJ   = 0,
  parameter int unsigned P_VDISP  = 25,
  parameter int unsigned P_VSROW  = 30,
  parameter int unsigned P_RMAX   = 7,
  parameter int unsigned P_START  = 0,
  parameter int unsigned VS_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 idx_we,
  input  logic                 dat_we,
  input  logic [DW-1:0]        wdata,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 de_o,
  output logic [MAW-1:0]       ma_o,
  output logic [RCW-1:0]       ra_o
);
  localparam cfg_t RST_CFG = '{
    htot:  HCW'(P_HTOT),  hdisp: HCW'(P_HDISP), hpos:  HCW'(P_HPOS),
    hwid:  HWW'(P_HWID),  vtot:  VCW'(P_VTOT),  vadj:  RCW'(P_VADJ),
    vdisp: VCW'(P_VDISP), vsrow: VCW'(P_VSROW), rmax:  RCW'(P_RMAX),
    start: MAW'(P_START)
  };

  cfg_t            cfg;
  logic [IDXW-1:0] reg_idx;
  logic [HCW-1:0]  hcnt;
  logic            h_end, line_start, hs_now;
  logic [RCW-1:0]  rcnt;
  logic [VCW-1:0]  vcnt;
  logic            in_adj, row_last_line, frame_wrap, v_disp, vs_now;
  logic [MAW-1:0]  ma_cnt;

  rtg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata),
    .sel_o(reg_idx), .cfg_o(cfg)
  );

  rtg_hgen u_hgen (
    .clk(clk), .rst(rst), .htot(cfg.htot), .hpos(cfg.hpos), .hwid(cfg.hwid),
    .hcnt(hcnt), .h_end(h_end), .line_start(line_start), .hs_now(hs_now)
  );

  rtg_vgen #(.VS_LINES(VS_LINES)) u_vgen (
    .clk(clk), .rst(rst), .h_end(h_end), .line_start(line_start),
    .vtot(cfg.vtot), .vadj(cfg.vadj), .vdisp(cfg.vdisp), .vsrow(cfg.vsrow),
    .rmax(cfg.rmax), .rcnt(rcnt), .vcnt(vcnt), .in_adj(in_adj),
    .row_last_line(row_last_line), .frame_wrap(frame_wrap),
    .v_disp(v_disp), .vs_now(vs_now)
  );

  rtg_addr #(.START_RST(MAW'(P_START))) u_addr (
    .clk(clk), .rst(rst), .h_end(h_end), .row_last_line(row_last_line),
    .frame_wrap(frame_wrap), .hdisp(cfg.hdisp), .start(cfg.start),
    .ma_cnt(ma_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      ma_o    <= '0;
      ra_o    <= '0;
    end else begin
      hsync_o <= hs_now;
      vsync_o <= vs_now;
      de_o    <= (hcnt < cfg.hdisp) && v_disp;
      ma_o    <= ma_cnt;
      ra_o    <= rcnt;
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            dat_we,
  input logic [IDXW-1:0] reg_idx,
  input cfg_t            cfg,
  input logic [HCW-1:0]  hcnt,
  input logic            h_end,
  input logic [RCW-1:0]  rcnt,
  input logic            in_adj,
  input logic            frame_wrap,
  input logic [MAW-1:0]  ma_cnt,
  input logic            hsync_o,
  input logic            vsync_o,
  input logic            de_o,
  input logic [MAW-1:0]  ma_o,
  input logic [RCW-1:0]  ra_o
);
  logic idx_real;
  assign idx_real = (reg_idx <= IX_VSROW) || (reg_idx == IX_RMAX) ||
                    (reg_idx == IX_STHI)  || (reg_idx == IX_STLO);

  // R4: a sync pulse can only begin at the programmed position
  a_r4_hs_rise_at_pos: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_o) |-> $past(hcnt) == $past(cfg.hpos));

  // R5: vertical sync begins on scan line 0 of a row
  a_r5_vs_first_raster: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_o) |-> ra_o == '0);

  // R9: the address counter takes the start value exactly at the frame wrap
  a_r9_start_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $past(frame_wrap) |-> ma_cnt == $past(cfg.start));

  // R7: consecutive displayed characters on one line have consecutive addresses
  a_r7_ma_step: assert property (@(posedge clk) disable iff (rst)
    (de_o && $past(de_o) && !$past(h_end, 2)) |-> ma_o == MAW'($past(ma_o) + 1'b1));

  // R8: the scan line counter moves only at a line end
  a_r8_ra_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(h_end) |-> $stable(rcnt));

  // R6: no display during adjust lines
  a_r6_no_de_in_adj: assert property (@(posedge clk) disable iff (rst)
    in_adj |=> !de_o);

  // R10: a data write to a non-existent index leaves every register unchanged
  a_r10_ignored_index: assert property (@(posedge clk) disable iff (rst)
    ($past(dat_we) && !$past(idx_real)) |-> cfg == $past(cfg));
endmodule

bind rtg_top rtg_checker u_rtg_checker (
  .clk(clk), .rst(rst), .dat_we(dat_we), .reg_idx(reg_idx), .cfg(cfg),
  .hcnt(hcnt), .h_end(h_end), .rcnt(rcnt), .in_adj(in_adj),
  .frame_wrap(frame_wrap), .ma_cnt(ma_cnt), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .de_o(de_o), .ma_o(ma_o), .ra_o(ra_o)
);

// File: tb/test_rtg_top.sv
`timescale 1ns/1ps
module test_rtg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_we = 1'b0;
  logic        dat_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic        hsync_o, vsync_o, de_o;
  logic [13:0] ma_o;
  logic [4:0]  ra_o;

  rtg_top i_rtg_top (
    .clk(clk), .rst(rst), .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .ma_o(ma_o), .ra_o(ra_o)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int htot, hdisp, hpos, hwid, vtot, vadj, vdisp, vsr, rmax;
  } tcfg_t;

  typedef struct {
    int at;
    bit de, hs, vs;
    int ma;
    int ra;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops the expected item for this cycle and compares
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      cur = sb_q.pop_front();
      if (cur.at != cyc) chk(1'b0, "R6", "scoreboard slot", cyc, cur.at);
      else begin
        chk(de_o == cur.de,    "R6", "display enable", int'(de_o), int'(cur.de));
        chk(hsync_o == cur.hs, "R4", "hsync", int'(hsync_o), int'(cur.hs));
        chk(vsync_o == cur.vs, "R5", "vsync", int'(vsync_o), int'(cur.vs));
        chk(int'(ra_o) == cur.ra, "R8", "row address", int'(ra_o), cur.ra);
        if (cur.de)
          chk(int'(ma_o) == cur.ma, "R7/R9", "memory address", int'(ma_o), cur.ma);
      end
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk); wdata = 8'(idx); idx_we = 1'b1;
    @(negedge clk); idx_we = 1'b0; wdata = 8'(val); dat_we = 1'b1;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wait_vs(input int n);
    bit pv;
    @(negedge clk); pv = vsync_o;
    for (int k = 0; k < n; k++) begin
      forever begin
        @(negedge clk);
        if (vsync_o && !pv) begin pv = 1'b1; break; end
        pv = vsync_o;
      end
    end
  endtask

  // Driver: anchors on a vsync rise, pushes one full frame of expectations
  task automatic check_frame(input tcfg_t c, input int s_a, input int s_b,
                             input int wr_at, input int wr_val);
    int hl, lr, nl, fl, c0, p0, last_hs, nrise;
    bit pv, phs, gap_bad;
    hl = c.htot + 1;
    lr = c.rmax + 1;
    nl = (c.vtot + 1) * lr;
    fl = (nl + c.vadj) * hl;
    @(negedge clk); pv = vsync_o;
    forever begin
      @(negedge clk);
      if (vsync_o && !pv) break;
      pv = vsync_o;
    end
    c0 = cyc;
    p0 = c.vsr * lr * hl;
    for (int i = 1; i <= fl; i++) begin
      exp_t e;
      int p, line, h, row, st;
      bit adj;
      p    = p0 + i;
      st   = (p >= fl) ? s_b : s_a;
      p    = p % fl;
      line = p / hl;
      h    = p % hl;
      adj  = (line >= nl);
      row  = adj ? 0 : line / lr;
      e.at = c0 + i;
      e.ra = adj ? line - nl : line % lr;
      e.de = !adj && (h < c.hdisp) && (row < c.vdisp);
      e.hs = (h >= c.hpos) && (h < c.hpos + c.hwid);
      e.vs = (line >= c.vsr * lr) && (line < c.vsr * lr + 16);
      e.ma = (st + row * c.hdisp + h) % 16384;
      sb_q.push_back(e);
    end
    fork
      begin
        pv = 1'b1; phs = hsync_o; last_hs = -1; nrise = 0; gap_bad = 1'b0;
        for (int i = 0; i < fl + 8; i++) begin
          @(negedge clk);
          if (hsync_o && !phs) begin
            if (last_hs >= 0 && cyc - last_hs != hl) gap_bad = 1'b1;
            last_hs = cyc;
            nrise++;
          end
          phs = hsync_o;
          if (vsync_o && !pv) break;
          pv = vsync_o;
        end
        chk(cyc - c0 == fl, "R3", "frame length in clocks", cyc - c0, fl);
        if (c.hwid > 0) begin
          chk(!gap_bad, "R2", "hsync period", int'(gap_bad), 0);
          chk(nrise == fl / hl, "R2", "lines per frame", nrise, fl / hl);
        end else begin
          chk(nrise == 0, "R4", "pulses at zero width", nrise, 0);
        end
      end
      begin
        if (wr_at >= 0) begin
          repeat (wr_at) @(negedge clk);
          wr(12, (wr_val >> 8) & 8'h3F);
          wr(13, wr_val & 8'hFF);
        end
      end
    join
  endtask

  task automatic check_reset_outputs();
    chk(!hsync_o && !vsync_o && !de_o, "R1", "sync/enable in reset",
        int'({hsync_o, vsync_o, de_o}), 0);
    chk(ma_o == '0 && ra_o == '0, "R1", "address in reset",
        int'(ma_o) + int'(ra_o), 0);
  endtask

  initial begin
    tcfg_t d, c2, c3;
    int fails_before;
    d  = '{htot:63, hdisp:40, hpos:46, hwid:14, vtot:38, vadj:0,
           vdisp:25, vsr:30, rmax:7};
    c2 = '{htot:7, hdisp:4, hpos:5, hwid:2, vtot:29, vadj:2,
           vdisp:10, vsr:12, rmax:0};
    c3 = c2;
    c3.hwid = 0;

    // R1: reset state
    repeat (5) @(negedge clk);
    check_reset_outputs();
    rst = 1'b0;

    // R2, R3, R4, R5, R6, R7, R8: default 312 x 64 frame
    check_frame(d, 0, 0, -1, 0);
    // R9: start rewritten at line 50 of the next frame; that frame unchanged
    check_frame(d, 0, 0, (19968 - 30 * 8 * 64) + 50 * 64, 'h1234);
    // R9: new start appears only after the following wrap
    check_frame(d, 0, 'h1234, -1, 0);

    // R1: reset again after running, registers back to defaults
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_outputs();
    rst = 1'b0;

    // R10: re-timing through the index/data port; one-line rows (R8),
    // adjust lines, 2-character sync, 14-bit address wrap
    wr(0, 7);  wr(1, 4);  wr(2, 5);  wr(3, 2);  wr(4, 29);
    wr(5, 2);  wr(6, 10); wr(7, 12); wr(9, 0);
    wr(12, 'h3F); wr(13, 'hFE);
    wait_vs(2);
    check_frame(c2, 'h3FFE, 'h3FFE, -1, 0);

    // R10: writes to non-existent indices must leave the timing untouched
    wr(8, 'hFF); wr(10, 'h00); wr(11, 'h55); wr(31, 'h01);
    fails_before = n_fail;
    wait_vs(1);
    check_frame(c2, 'h3FFE, 'h3FFE, -1, 0);
    repeat (4) @(negedge clk);
    chk(n_fail == fails_before, "R10", "mismatches after ignored writes",
        n_fail - fails_before, 0);

    // R4: width zero removes the horizontal pulse
    wr(3, 0);
    wait_vs(2);
    check_frame(c3, 'h3FFE, 'h3FFE, -1, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion (cycle %0d)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule